// File: doc/BRIEF.md
# Per-CPU Bus Interrupt Receive Mailbox

This block takes interrupt messages arriving from a system bus and parks each one in a single-entry mailbox owned by the targeted CPU. A message names a target CPU and a source identifier, and carries two 64-bit data words. Each mailbox has a busy flag. A message for a CPU whose mailbox is free is accepted in the same cycle. The payload is latched and the busy flag is raised. One cycle later an interrupt post goes out to that CPU, tagged with the shared 6-bit vector. A message for a CPU whose mailbox is occupied is rejected, and the sender has to retry.

Software handles the busy flags through a small register write port. An indexed array gives one busy register per CPU, 8 bytes apart. A single alias address always reaches the busy flag of the CPU that performs the access. A third address loads the shared vector. Software normally drains a mailbox and then writes the busy flag to 0 to reopen it. The stored payload of any CPU can be viewed through a peek select.

Top module: `bus_irq_mailbox`

## Requirements
- R1: After reset, every busy flag, source field, data word and the vector read 0, and no interrupt post is active.
- R2: While `msg_valid` is high, `msg_accept` is high in the same cycle exactly when the target CPU's busy flag is 0, and `msg_reject` is high exactly when it is 1. The two are never high together.
- R3: An accepted message sets the target CPU's busy flag on the next clock edge and stores its source identifier and both data words for that CPU.
- R4: A rejected message leaves the target CPU's stored source and data words unchanged, and produces no interrupt post.
- R5: One cycle after an accept, `post_valid` is high for exactly one cycle. `post_cpu` carries the target CPU and `post_vec` carries the vector value held at the time of the accept.
- R6: A write to address `BUSY_BASE + 8*i` (i below NUM_CPU) sets CPU i's busy flag to write data bit 5, and leaves all other busy flags as they were.
- R7: A write to `ALIAS_ADDR` sets the busy flag of CPU `reg_cpu` (the CPU making the access) to write data bit 5, and leaves all other busy flags as they were.
- R8: A write to `VEC_ADDR` loads the vector from write data bits 5:0. The upper bits are ignored.
- R9: When a software busy write and an accepted message target the same CPU in one cycle, the message wins: the busy flag ends at 1 and the payload is stored. A software write to a different CPU in that cycle still takes effect.
- R10: A write to any address outside the busy array, the alias and the vector register changes no busy flag and does not change the vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | Incoming bus interrupt message present |
| msg_cpu | input | CPU_W | Target CPU of the message |
| msg_src | input | SRC_W | Source identifier of the message |
| msg_d0 | input | DATA_W | First data word |
| msg_d1 | input | DATA_W | Second data word |
| msg_accept | output | 1 | Message taken into the mailbox (combinational) |
| msg_reject | output | 1 | Message refused, mailbox busy (combinational) |
| post_valid | output | 1 | One-cycle interrupt post to a CPU |
| post_cpu | output | CPU_W | CPU receiving the post |
| post_vec | output | VEC_W | Vector carried by the post |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register write address |
| reg_wdata | input | 64 | Register write data |
| reg_cpu | input | CPU_W | CPU issuing the register access |
| busy_flags | output | NUM_CPU | Busy flag of each CPU |
| vec_out | output | VEC_W | Current shared vector |
| peek_cpu | input | CPU_W | Mailbox selected for viewing |
| peek_src | output | SRC_W | Stored source of the selected mailbox |
| peek_d0 | output | DATA_W | Stored first data word of the selected mailbox |
| peek_d1 | output | DATA_W | Stored second data word of the selected mailbox |

## Verification
Two functions can fall on the same mailbox in one cycle: a message accept and a software write of that CPU's busy flag. The bench provokes this by presenting a message and an indexed or alias write that clears busy for the same CPU in the same cycle. It then checks that the busy flag ends at 1 and that the new payload is present. In a second cycle, the message and the write target different CPUs, and both updates must be visible afterwards.

// File: rtl/bus_irq_mailbox_pkg.sv
`timescale 1ns/1ps
package bus_irq_mailbox_pkg;
  // byte stride of the indexed busy array is 1 << STRIDE_SHIFT
  localparam int unsigned STRIDE_SHIFT = 3;
  // bit of the write data that carries a busy flag value
  localparam int unsigned BUSY_BIT     = 5;

  // Offset of an address into the busy array, as a slot number.
  function automatic int unsigned slot_of(input int unsigned addr,
                                          input int unsigned base);
    return (addr - base) >> STRIDE_SHIFT;
  endfunction

  // True when an address lies within a busy array of n slots.
  function automatic logic in_array(input int unsigned addr,
                                    input int unsigned base,
                                    input int unsigned n);
    return (addr >= base) && ((addr - base) < (n << STRIDE_SHIFT));
  endfunction
endpackage

// File: rtl/mbx_reg_decode.sv
`timescale 1ns/1ps
module mbx_reg_decode
  import bus_irq_mailbox_pkg::*;
#(
  parameter int unsigned NUM_CPU    = 4,
  parameter int unsigned CPU_W      = 2,
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned BUSY_BASE  = 'h100,
  parameter int unsigned ALIAS_ADDR = 'h180,
  parameter int unsigned VEC_ADDR   = 'h1C0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [CPU_W-1:0]   cpu,
  output logic [NUM_CPU-1:0] busy_we,
  output logic               vec_we
);
  logic        arr_hit;
  logic        alias_hit;
  int unsigned slot;

  always_comb begin
    arr_hit   = we && in_array(32'(addr), BUSY_BASE, NUM_CPU);
    alias_hit = we && (32'(addr) == ALIAS_ADDR);
    vec_we    = we && (32'(addr) == VEC_ADDR);
    slot      = slot_of(32'(addr), BUSY_BASE);
  end

  for (genvar i = 0; i < NUM_CPU; i++) begin : g_we
    assign busy_we[i] = (arr_hit && slot == i) ||
                        (alias_hit && 32'(cpu) == i);
  end

  // one address reaches at most one busy flag (R6, R7)
  p_one_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(busy_we));
  // the vector register never shares a write with a busy flag (R10)
  p_vec_apart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    vec_we |-> busy_we == '0);
endmodule

// File: rtl/mbx_slot.sv
`timescale 1ns/1ps
module mbx_slot #(
  parameter int unsigned SRC_W  = 6,
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_i,
  input  logic              sw_we_i,
  input  logic              sw_val_i,
  input  logic [SRC_W-1:0]  src_i,
  input  logic [DATA_W-1:0] d0_i,
  input  logic [DATA_W-1:0] d1_i,
  output logic              busy_o,
  output logic [SRC_W-1:0]  src_o,
  output logic [DATA_W-1:0] d0_o,
  output logic [DATA_W-1:0] d1_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      src_o  <= '0;
      d0_o   <= '0;
      d1_o   <= '0;
    end else begin
      if (acc_i) begin
        busy_o <= 1'b1;           // message beats software write (R9)
        src_o  <= src_i;
        d0_o   <= d0_i;
        d1_o   <= d1_i;
      end else if (sw_we_i) begin
        busy_o <= sw_val_i;
      end
    end
  end

  p_accept_fills_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_i |=> busy_o && src_o == $past(src_i) && d0_o == $past(d0_i)
              && d1_o == $past(d1_i));
  p_idle_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_i |=> $stable(src_o) && $stable(d0_o) && $stable(d1_o));
  p_msg_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_i && sw_we_i && !sw_val_i) |=> busy_o);
endmodule

// File: rtl/bus_irq_mailbox.sv
`timescale 1ns/1ps
module bus_irq_mailbox
  import bus_irq_mailbox_pkg::*;
#(
  parameter int unsigned NUM_CPU    = 4,
  parameter int unsigned SRC_W      = 6,
  parameter int unsigned DATA_W     = 64,
  parameter int unsigned VEC_W      = 6,
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned BUSY_BASE  = 'h100,
  parameter int unsigned ALIAS_ADDR = 'h180,
  parameter int unsigned VEC_ADDR   = 'h1C0,
  localparam int unsigned CPU_W     = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               msg_valid,
  input  logic [CPU_W-1:0]   msg_cpu,
  input  logic [SRC_W-1:0]   msg_src,
  input  logic [DATA_W-1:0]  msg_d0,
  input  logic [DATA_W-1:0]  msg_d1,
  output logic               msg_accept,
  output logic               msg_reject,
  output logic               post_valid,
  output logic [CPU_W-1:0]   post_cpu,
  output logic [VEC_W-1:0]   post_vec,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [63:0]        reg_wdata,
  input  logic [CPU_W-1:0]   reg_cpu,
  output logic [NUM_CPU-1:0] busy_flags,
  output logic [VEC_W-1:0]   vec_out,
  input  logic [CPU_W-1:0]   peek_cpu,
  output logic [SRC_W-1:0]   peek_src,
  output logic [DATA_W-1:0]  peek_d0,
  output logic [DATA_W-1:0]  peek_d1
);
  logic [NUM_CPU-1:0] busy_we;
  logic               vec_we;
  logic [NUM_CPU-1:0] acc_vec;
  logic               cpu_ok;
  logic [SRC_W-1:0]   src_a [NUM_CPU];
  logic [DATA_W-1:0]  d0_a  [NUM_CPU];
  logic [DATA_W-1:0]  d1_a  [NUM_CPU];

  mbx_reg_decode #(
    .NUM_CPU(NUM_CPU), .CPU_W(CPU_W), .ADDR_W(ADDR_W),
    .BUSY_BASE(BUSY_BASE), .ALIAS_ADDR(ALIAS_ADDR), .VEC_ADDR(VEC_ADDR)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .cpu(reg_cpu),
    .busy_we(busy_we), .vec_we(vec_we)
  );

  // a target beyond the populated CPUs is never accepted
  assign cpu_ok     = 32'(msg_cpu) < NUM_CPU;
  assign msg_accept = msg_valid && cpu_ok && !busy_flags[msg_cpu];
  assign msg_reject = msg_valid && !msg_accept;

  for (genvar i = 0; i < NUM_CPU; i++) begin : g_slot
    assign acc_vec[i] = msg_accept && (32'(msg_cpu) == i);
    mbx_slot #(.SRC_W(SRC_W), .DATA_W(DATA_W)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .acc_i(acc_vec[i]), .sw_we_i(busy_we[i]),
      .sw_val_i(reg_wdata[BUSY_BIT]),
      .src_i(msg_src), .d0_i(msg_d0), .d1_i(msg_d1),
      .busy_o(busy_flags[i]), .src_o(src_a[i]), .d0_o(d0_a[i]), .d1_o(d1_a[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_out    <= '0;
      post_valid <= 1'b0;
      post_cpu   <= '0;
      post_vec   <= '0;
    end else begin
      if (vec_we) vec_out <= reg_wdata[VEC_W-1:0];
      post_valid <= msg_accept;
      if (msg_accept) begin
        post_cpu <= msg_cpu;
        post_vec <= vec_out;
      end
    end
  end

  assign peek_src = src_a[peek_cpu];
  assign peek_d0  = d0_a[peek_cpu];
  assign peek_d1  = d1_a[peek_cpu];

  p_acc_xor_rej_r2: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_accept != msg_reject));
  p_no_resp_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_valid |-> !msg_accept && !msg_reject);
  p_post_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    msg_accept |=> post_valid && post_cpu == $past(msg_cpu)
                   && post_vec == $past(vec_out));
  p_no_post_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_accept |=> !post_valid);
  p_vec_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vec_we |=> vec_out == $past(reg_wdata[VEC_W-1:0]));
  p_vec_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_we |=> $stable(vec_out));
endmodule

// File: tb/bus_irq_mailbox_bench.sv
`timescale 1ns/1ps
module bus_irq_mailbox_bench;
  localparam int NC = 4;
  localparam int unsigned BASE  = 'h100;
  localparam int unsigned ALIAS = 'h180;
  localparam int unsigned VADDR = 'h1C0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        msg_valid = 1'b0;
  logic [1:0]  msg_cpu = '0;
  logic [5:0]  msg_src = '0;
  logic [63:0] msg_d0 = '0, msg_d1 = '0;
  logic        msg_accept, msg_reject, post_valid;
  logic [1:0]  post_cpu;
  logic [5:0]  post_vec;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic [1:0]  reg_cpu = '0;
  logic [3:0]  busy_flags;
  logic [5:0]  vec_out;
  logic [1:0]  peek_cpu = '0;
  logic [5:0]  peek_src;
  logic [63:0] peek_d0, peek_d1;

  int n_chk = 0;
  int n_fail = 0;
  logic [3:0] exp_busy = '0;

  always #10 clk = ~clk;   // 50 MHz

  bus_irq_mailbox u_bus_irq_mailbox (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_cpu(msg_cpu),
    .msg_src(msg_src), .msg_d0(msg_d0), .msg_d1(msg_d1),
    .msg_accept(msg_accept), .msg_reject(msg_reject),
    .post_valid(post_valid), .post_cpu(post_cpu), .post_vec(post_vec),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_cpu(reg_cpu), .busy_flags(busy_flags), .vec_out(vec_out),
    .peek_cpu(peek_cpu), .peek_src(peek_src), .peek_d0(peek_d0),
    .peek_d1(peek_d1)
  );

  task automatic check(input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // drive at the falling edge, everything idle again after the next rising edge
  task automatic idle();
    msg_valid = 1'b0;
    reg_we    = 1'b0;
  endtask

  task automatic set_msg(input logic [1:0] c, input logic [5:0] s,
                         input logic [63:0] a, input logic [63:0] b);
    msg_valid = 1'b1; msg_cpu = c; msg_src = s; msg_d0 = a; msg_d1 = b;
  endtask

  task automatic set_wr(input int unsigned a, input logic [63:0] d,
                        input logic [1:0] c);
    reg_we = 1'b1; reg_addr = 12'(a); reg_wdata = d; reg_cpu = c;
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic check_slot(input string req, input logic [1:0] c,
                            input logic [5:0] s, input logic [63:0] a,
                            input logic [63:0] b);
    peek_cpu = c; #1;
    check(req, 64'(peek_src), 64'(s));
    check(req, peek_d0, a);
    check(req, peek_d1, b);
  endtask

  task automatic t_reset();
    check("R1 busy", 64'(busy_flags), 64'h0);
    check("R1 vec", 64'(vec_out), 64'h0);
    check("R1 post", 64'(post_valid), 64'h0);
    for (int i = 0; i < NC; i++) check_slot("R1 slot", 2'(i), '0, '0, '0);
  endtask

  task automatic t_accept();
    @(negedge clk); set_wr(VADDR, 64'hFFEA, 2'd0);      // bits 5:0 = 0x2A
    step();
    check("R8 vec load", 64'(vec_out), 64'h2A);
    @(negedge clk); idle();
    set_msg(2'd2, 6'h11, 64'hDEAD_BEEF_0000_0001, 64'h1234_5678_9ABC_DEF0);
    #2;
    check("R2 accept", 64'(msg_accept), 64'h1);
    check("R2 reject", 64'(msg_reject), 64'h0);
    step();
    exp_busy[2] = 1'b1;
    check("R3 busy", 64'(busy_flags), 64'(exp_busy));
    check_slot("R3 payload", 2'd2, 6'h11, 64'hDEAD_BEEF_0000_0001,
               64'h1234_5678_9ABC_DEF0);
    check("R5 post", 64'(post_valid), 64'h1);
    check("R5 cpu", 64'(post_cpu), 64'h2);
    check("R5 vec", 64'(post_vec), 64'h2A);
    @(negedge clk); idle();
    step();
    check("R5 one cycle", 64'(post_valid), 64'h0);
  endtask

  task automatic t_reject();
    @(negedge clk); set_msg(2'd2, 6'h3F, 64'hFFFF, 64'hEEEE);
    #2;
    check("R2 reject busy", 64'(msg_reject), 64'h1);
    check("R2 no accept", 64'(msg_accept), 64'h0);
    step();
    check("R4 no post", 64'(post_valid), 64'h0);
    check_slot("R4 kept", 2'd2, 6'h11, 64'hDEAD_BEEF_0000_0001,
               64'h1234_5678_9ABC_DEF0);
    @(negedge clk); idle();
  endtask

  task automatic t_indexed();
    @(negedge clk); set_wr(BASE + 2*8, 64'hFFFF_FFFF_FFFF_FFDF, 2'd0); // bit5=0
    step(); exp_busy[2] = 1'b0;
    check("R6 clear idx2", 64'(busy_flags), 64'(exp_busy));
    @(negedge clk); set_wr(BASE + 3*8, 64'h20, 2'd1);
    step(); exp_busy[3] = 1'b1;
    check("R6 set idx3", 64'(busy_flags), 64'(exp_busy));
    @(negedge clk); set_wr(BASE + 3*8, 64'h1F, 2'd1);
    step(); exp_busy[3] = 1'b0;
    check("R6 clear idx3", 64'(busy_flags), 64'(exp_busy));
    @(negedge clk); idle();
  endtask

  task automatic t_alias();
    @(negedge clk); set_wr(ALIAS, 64'h20, 2'd1);
    step(); exp_busy[1] = 1'b1;
    check("R7 alias set cpu1", 64'(busy_flags), 64'(exp_busy));
    @(negedge clk); set_wr(ALIAS, 64'h0, 2'd1);
    step(); exp_busy[1] = 1'b0;
    check("R7 alias clear cpu1", 64'(busy_flags), 64'(exp_busy));
    @(negedge clk); idle();
  endtask

  task automatic t_collision();
    // same CPU: message plus clearing write
    @(negedge clk);
    set_msg(2'd0, 6'h05, 64'hA5A5, 64'h5A5A);
    set_wr(BASE + 0*8, 64'h0, 2'd3);
    step(); exp_busy[0] = 1'b1;
    check("R9 msg wins busy", 64'(busy_flags), 64'(exp_busy));
    check_slot("R9 msg wins data", 2'd0, 6'h05, 64'hA5A5, 64'h5A5A);
    // different CPUs: message to 1, alias write sets 3
    @(negedge clk);
    set_msg(2'd1, 6'h07, 64'h77, 64'h88);
    set_wr(ALIAS, 64'h20, 2'd3);
    step(); exp_busy[1] = 1'b1; exp_busy[3] = 1'b1;
    check("R9 both apply", 64'(busy_flags), 64'(exp_busy));
    @(negedge clk); idle();
  endtask

  task automatic t_other_addr();
    @(negedge clk); set_wr('h080, 64'hFFFF_FFFF_FFFF_FFC0, 2'd2);
    step();
    check("R10 busy untouched", 64'(busy_flags), 64'(exp_busy));
    check("R10 vec untouched", 64'(vec_out), 64'h2A);
    @(negedge clk); set_wr(BASE + NC*8, 64'h0, 2'd0);  // just past the array
    step();
    check("R10 past array", 64'(busy_flags), 64'(exp_busy));
    @(negedge clk); idle();
  endtask

  initial begin
    #(20 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_accept();
    t_reject();
    t_indexed();
    t_alias();
    t_collision();
    t_other_addr();
    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule